// File: doc/BRIEF.md
# Memory Reference Protection Checker

This block sits between a processor and its memory. It screens each memory reference the processor issues against two forbidden address windows. The first window is fixed when the design is built. The second is set at run time by a pair of boundary registers. A reference whose address lands in either window is refused in the same cycle. One cycle later, a one-cycle violation pulse is raised, and it carries the refused address.

The screening follows a single status input that reports whether the interrupt system is enabled. While interrupts are enabled, a user program is running, so every reference is screened and the boundary registers are locked. While interrupts are disabled, supervisor code is running, so every reference passes unchecked and the boundaries may be rewritten. This split means a user program can never move its own fence.

Top module: `mem_guard`

## Requirements
- R1: After a synchronous reset, the run-time window is empty. With interrupts enabled, any address outside the fixed window is granted.
- R2: With interrupts enabled, an address from FIX_LO to FIX_HI inclusive is suppressed. FIX_HI+1 is granted. The defaults are 0x0000 and 0x00FF.
- R3: With interrupts enabled, an address from the lower bound to the upper bound inclusive is suppressed. The addresses one below the lower bound and one above the upper bound are granted.
- R4: A boundary write with interrupts disabled takes effect from the next cycle. `bnd_sel` = 0 selects the lower bound and `bnd_sel` = 1 selects the upper bound.
- R5: A boundary write made while interrupts are enabled has no effect on either bound.
- R6: With interrupts disabled, every valid request is granted and no violation pulse is produced.
- R7: `grant` and `suppress` are combinational in the request cycle and are never both high. Both are low when `req_valid` is low.
- R8: `viol_pulse` is high for exactly the one cycle after each suppressed request. In that cycle, `viol_addr` holds the refused address. Back-to-back refusals give back-to-back pulses.
- R9: A run-time window whose lower bound is above its upper bound matches no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Interrupt system enabled (1 = checking on, bounds locked) |
| req_valid | input | 1 | Memory reference present |
| req_addr | input | AW | Reference address |
| bnd_we | input | 1 | Boundary register write strobe |
| bnd_sel | input | 1 | 0 = lower bound, 1 = upper bound |
| bnd_wdata | input | AW | New boundary value |
| grant | output | 1 | Reference may proceed |
| suppress | output | 1 | Reference refused |
| viol_pulse | output | 1 | One-cycle violation pulse, registered |
| viol_addr | output | AW | Address that caused the last violation |

## Verification
Two functions can fall in the same cycle: a boundary write and a memory reference. The bench provokes this in two ways. First, it drives a write that should be ignored, because interrupts are enabled, alongside a reference that lies inside the current window. Second, it drives a write that is accepted, because interrupts are disabled, alongside a reference in the old window. In the first case, the reference must be suppressed and the window must stay where it was. In the second case, the reference must be granted in its own cycle, and the new bound must govern only the following references once checking resumes.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
  typedef enum logic {
    SEL_LOWER = 1'b0,
    SEL_UPPER = 1'b1
  } bnd_sel_e;
endpackage

// File: rtl/guard_window.sv
module guard_window #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit
);
  // Both ends inclusive; lo > hi yields no match (R9).
  logic above_lo;
  logic below_hi;
  always_comb begin
    above_lo = (addr >= lo);
    below_hi = (addr <= hi);
    hit      = above_lo && below_hi;
  end
endmodule

// File: rtl/guard_bounds.sv
module guard_bounds
  import mem_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_en,
  input  logic          we,
  input  bnd_sel_e      sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] lower,
  output logic [AW-1:0] upper
);
  localparam logic [AW-1:0] EMPTY_LO = '1;
  localparam logic [AW-1:0] EMPTY_HI = '0;

  logic wr_ok;
  assign wr_ok = we && !irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      lower <= EMPTY_LO;
      upper <= EMPTY_HI;
    end else if (wr_ok) begin
      if (sel == SEL_LOWER) lower <= wdata;
      else                  upper <= wdata;
    end
  end

  a_r5_locked_when_enabled: assert property (@(posedge clk) disable iff (rst)
    irq_en |=> ($stable(lower) && $stable(upper)));

  a_r4_lower_written: assert property (@(posedge clk) disable iff (rst)
    (we && !irq_en && sel == SEL_LOWER) |=> (lower == $past(wdata)));

  a_r4_upper_written: assert property (@(posedge clk) disable iff (rst)
    (we && !irq_en && sel == SEL_UPPER) |=> (upper == $past(wdata)));
endmodule

// File: rtl/guard_alarm.sv
module guard_alarm #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          refused,
  input  logic [AW-1:0] addr,
  output logic          pulse,
  output logic [AW-1:0] vaddr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      vaddr <= '0;
    end else begin
      pulse <= refused;
      if (refused) vaddr <= addr;
    end
  end

  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    refused |=> (pulse && vaddr == $past(addr)));

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !refused |=> !pulse);
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
#(
  parameter int              AW     = 16,
  parameter logic [AW-1:0]   FIX_LO = 16'h0000,
  parameter logic [AW-1:0]   FIX_HI = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_en,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          bnd_we,
  input  logic          bnd_sel,
  input  logic [AW-1:0] bnd_wdata,
  output logic          grant,
  output logic          suppress,
  output logic          viol_pulse,
  output logic [AW-1:0] viol_addr
);
  localparam int NWIN = 2;

  logic [AW-1:0]   var_lo;
  logic [AW-1:0]   var_hi;
  logic [NWIN-1:0] win_hit;
  logic [AW-1:0]   win_lo [NWIN];
  logic [AW-1:0]   win_hi [NWIN];
  logic            any_hit;
  logic            checking;

  guard_bounds #(.AW(AW)) u_bounds (
    .clk   (clk),
    .rst   (rst),
    .irq_en(irq_en),
    .we    (bnd_we),
    .sel   (bnd_sel_e'(bnd_sel)),
    .wdata (bnd_wdata),
    .lower (var_lo),
    .upper (var_hi)
  );

  always_comb begin
    win_lo[0] = FIX_LO;
    win_hi[0] = FIX_HI;
    win_lo[1] = var_lo;
    win_hi[1] = var_hi;
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    guard_window #(.AW(AW)) u_win (
      .addr(req_addr),
      .lo  (win_lo[w]),
      .hi  (win_hi[w]),
      .hit (win_hit[w])
    );
  end

  always_comb begin
    checking = irq_en;
    any_hit  = |win_hit;
    suppress = req_valid && checking && any_hit;
    grant    = req_valid && !suppress;
  end

  guard_alarm #(.AW(AW)) u_alarm (
    .clk    (clk),
    .rst    (rst),
    .refused(suppress),
    .addr   (req_addr),
    .pulse  (viol_pulse),
    .vaddr  (viol_addr)
  );

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(grant && suppress));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!grant && !suppress));

  a_r6_open_when_disabled: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !irq_en) |-> grant);

  a_r2_fixed_refused: assert property (@(posedge clk) disable iff (rst)
    (req_valid && irq_en && req_addr >= FIX_LO && req_addr <= FIX_HI) |-> suppress);

  a_r9_inverted_empty: assert property (@(posedge clk) disable iff (rst)
    (var_lo > var_hi) |-> !win_hit[1]);
endmodule

// File: tb/mem_guard_bench.sv
module mem_guard_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq_en = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          bnd_we = 1'b0;
  logic          bnd_sel = 1'b0;
  logic [AW-1:0] bnd_wdata = '0;
  logic          grant, suppress, viol_pulse;
  logic [AW-1:0] viol_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_guard #(.AW(AW)) u_mem_guard (
    .clk(clk), .rst(rst), .irq_en(irq_en), .req_valid(req_valid),
    .req_addr(req_addr), .bnd_we(bnd_we), .bnd_sel(bnd_sel),
    .bnd_wdata(bnd_wdata), .grant(grant), .suppress(suppress),
    .viol_pulse(viol_pulse), .viol_addr(viol_addr)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One reference; checks grant/suppress in-cycle and pulse one cycle later.
  task automatic access(input string req, input logic [AW-1:0] a,
                        input logic en, input logic exp_sup);
    @(negedge clk);
    irq_en = en; req_valid = 1'b1; req_addr = a;
    #2;
    check(req, "grant", {31'd0, grant}, {31'd0, ~exp_sup});
    check(req, "suppress", {31'd0, suppress}, {31'd0, exp_sup});
    @(posedge clk); #2;
    req_valid = 1'b0;
    check(req, "viol_pulse", {31'd0, viol_pulse}, {31'd0, exp_sup});
    if (exp_sup) check(req, "viol_addr", {16'd0, viol_addr}, {16'd0, a});
  endtask

  task automatic wr_bound(input logic en, input logic sel, input logic [AW-1:0] d);
    @(negedge clk);
    irq_en = en; bnd_we = 1'b1; bnd_sel = sel; bnd_wdata = d;
    @(negedge clk);
    bnd_we = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1", "pulse after reset", {31'd0, viol_pulse}, 32'd0);
    access("R1", 16'h1234, 1'b1, 1'b0);
    access("R1", 16'hFFFF, 1'b1, 1'b0);
    access("R1", 16'h0100, 1'b1, 1'b0);
  endtask

  task automatic t_fixed;
    access("R2", 16'h0000, 1'b1, 1'b1);
    access("R2", 16'h00FF, 1'b1, 1'b1);
    access("R2", 16'h0042, 1'b1, 1'b1);
    access("R2", 16'h0100, 1'b1, 1'b0);
  endtask

  task automatic t_variable;
    wr_bound(1'b0, 1'b0, 16'h4000);   // R4 lower
    wr_bound(1'b0, 1'b1, 16'h40FF);   // R4 upper
    access("R4", 16'h4080, 1'b1, 1'b1);
    access("R3", 16'h3FFF, 1'b1, 1'b0);
    access("R3", 16'h4000, 1'b1, 1'b1);
    access("R3", 16'h40FF, 1'b1, 1'b1);
    access("R3", 16'h4100, 1'b1, 1'b0);
  endtask

  task automatic t_locked;
    // R5: write attempt while enabled, in the same cycle as a hit
    @(negedge clk);
    irq_en = 1'b1; bnd_we = 1'b1; bnd_sel = 1'b0; bnd_wdata = 16'h9000;
    req_valid = 1'b1; req_addr = 16'h4050;
    #2;
    check("R5", "same-cycle suppress", {31'd0, suppress}, 32'd1);
    @(negedge clk);
    bnd_we = 1'b0; req_valid = 1'b0;
    wr_bound(1'b1, 1'b1, 16'h0000);
    access("R5", 16'h4000, 1'b1, 1'b1);
    access("R5", 16'h40FF, 1'b1, 1'b1);
    access("R5", 16'h9000, 1'b1, 1'b0);
  endtask

  task automatic t_disabled;
    access("R6", 16'h0010, 1'b0, 1'b0);
    access("R6", 16'h4010, 1'b0, 1'b0);
    // accepted write alongside a reference in the old window
    @(negedge clk);
    irq_en = 1'b0; bnd_we = 1'b1; bnd_sel = 1'b0; bnd_wdata = 16'h5000;
    req_valid = 1'b1; req_addr = 16'h4010;
    #2;
    check("R6", "same-cycle grant", {31'd0, grant}, 32'd1);
    @(negedge clk);
    bnd_we = 1'b0; req_valid = 1'b0;
    check("R6", "no pulse", {31'd0, viol_pulse}, 32'd0);
    // lower 0x5000 > upper 0x40FF: window empty
    access("R9", 16'h4010, 1'b1, 1'b0);
    access("R9", 16'h5000, 1'b1, 1'b0);
    access("R9", 16'h40FF, 1'b1, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    irq_en = 1'b1; req_valid = 1'b0; req_addr = 16'h0010;
    #2;
    check("R7", "idle grant", {31'd0, grant}, 32'd0);
    check("R7", "idle suppress", {31'd0, suppress}, 32'd0);
    @(posedge clk); #2;
    check("R7", "idle pulse", {31'd0, viol_pulse}, 32'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    irq_en = 1'b1; req_valid = 1'b1; req_addr = 16'h0011;
    @(posedge clk); #2;
    check("R8", "pulse 1", {31'd0, viol_pulse}, 32'd1);
    check("R8", "addr 1", {16'd0, viol_addr}, 32'h0011);
    req_addr = 16'h00EE;
    @(posedge clk); #2;
    check("R8", "pulse 2", {31'd0, viol_pulse}, 32'd1);
    check("R8", "addr 2", {16'd0, viol_addr}, 32'h00EE);
    req_valid = 1'b0;
    @(posedge clk); #2;
    check("R8", "pulse ends", {31'd0, viol_pulse}, 32'd0);
    check("R8", "addr held", {16'd0, viol_addr}, 32'h00EE);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_variable();
    t_locked();
    t_disabled();
    t_idle();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule